// File: doc/BRIEF.md
# Signed-Amount Shift and Rotate Unit

The unit takes a data word, a 3-bit operation code and a signed shift count. It returns the word shifted or rotated by the magnitude of that count. Six operations are provided: logical shifts in both directions, arithmetic shifts in both directions, and rotates in both directions. When the count is negative, each operation is replaced by its mirror in the other direction. This means a single count port can move data either way without a separate direction input.

The caller raises a strobe for one cycle with the operands. On the next rising clock edge the result register loads and a valid flag rises beside it for one cycle. A new strobe may follow in every cycle. The reset is synchronous and active-low.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 000 is a logical left shift and 001 is a logical right shift. Both fill the vacated positions with 0, so 1100 shifted left by 2 gives 0000 and 1101 shifted right by 3 gives 0001.
- R2: Operation code 010 is an arithmetic left shift. It fills the vacated low positions with the current least significant bit, so 0111 by 1 gives 1111 and 1110 by 1 gives 1100.
- R3: Operation code 011 is an arithmetic right shift. It fills the vacated high positions with the sign bit, so 1100 by 1 gives 1110.
- R4: Operation code 100 rotates left and 101 rotates right. Bits that leave one end re-enter at the other end, so 1100 rotated either way by 2 gives 0011.
- R5: A negative count applies the mirror operation by the count's magnitude. The mirror pairs are the codes that differ only in bit 0. So 1100 arithmetic-right by -1 gives 1000, rotate-left by -1 gives 0110, and rotate-right by -1 gives 1001.
- R6: For the four shifts, a magnitude of WIDTH or more gives all zeros (logical) or all copies of the fill bit (arithmetic). For rotates, the magnitude is taken modulo WIDTH.
- R7: A count of zero returns the data unchanged for every code. Codes 110 and 111 return the data unchanged for any count.
- R8: The count is a WIDTH+1-bit two's complement value. Its most negative value, -2^WIDTH, is treated as magnitude 2^WIDTH without overflow.
- R9: The result and valid flag load on the rising edge after a cycle with the strobe high. Valid is low after every cycle without a strobe, and the result then holds its last value.
- R10: A low reset at a rising edge clears the result and the valid flag, even if the strobe is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_strobe | input | 1 | Operands valid this cycle |
| op_code | input | 3 | Operation select (see R1 to R7) |
| op_data | input | WIDTH | Word to shift or rotate |
| op_count | input | WIDTH+1 | Signed shift count, two's complement |
| res_data | output | WIDTH | Registered result |
| res_valid | output | 1 | Result loaded on the previous edge |

## Verification
Two behaviours can meet in the same cycle: the direction swap caused by a negative count, and the saturation or modulo reduction caused by a large magnitude. The most negative count, -2^WIDTH, triggers both at once. The bench sweeps every code, every data word and every count, including all counts whose magnitude reaches or exceeds WIDTH with either sign. Each result is judged against a bit-by-bit model that first mirrors the operation and then indexes past the word's edges. A second coincidence, a strobe in the same cycle as reset, is provoked directly, and the bench expects reset to win.

// File: rtl/sru_pkg.sv
// Shared types for the shift/rotate unit.
// Assumes: codes that differ only in bit 0 form a mirror pair.
package sru_pkg;
    typedef enum logic [2:0] {
        OP_LSL  = 3'b000,
        OP_LSR  = 3'b001,
        OP_ASL  = 3'b010,
        OP_ASR  = 3'b011,
        OP_ROL  = 3'b100,
        OP_ROR  = 3'b101,
        OP_PSA  = 3'b110,
        OP_PSB  = 3'b111
    } sru_op_e;

    // Mirror of an operation in the opposite direction; pass codes map to themselves.
    function automatic sru_op_e sru_mirror(input sru_op_e op);
        if (op == OP_PSA || op == OP_PSB) return op;
        return sru_op_e'(op ^ 3'b001);
    endfunction
endpackage

// File: rtl/sru_count_decode.sv
// Splits a signed count into direction-resolved operation and amounts.
// Assumes: count is WIDTH+1-bit two's complement; WIDTH >= 2.
module sru_count_decode
    import sru_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]                 code_in,
    input  logic [WIDTH:0]             count_in,
    output sru_op_e                    op_eff,
    output logic                       sh_over,
    output logic [$clog2(WIDTH)-1:0]   sh_amt,
    output logic [$clog2(WIDTH)-1:0]   rot_amt
);
    localparam int AMT_W = $clog2(WIDTH);
    localparam int MAG_W = WIDTH + 1;
    localparam bit POW2  = (1 << AMT_W) == WIDTH;

    logic             neg;
    logic [MAG_W-1:0] mag;

    // Magnitude without overflow: -2^WIDTH reads as unsigned 2^WIDTH.
    always_comb begin
        neg = count_in[WIDTH];
        mag = neg ? (~count_in + 1'b1) : count_in;
    end

    // Direction resolution and shift saturation.
    always_comb begin
        op_eff  = neg ? sru_mirror(sru_op_e'(code_in)) : sru_op_e'(code_in);
        sh_over = mag >= MAG_W'(WIDTH);
        sh_amt  = sh_over ? '0 : mag[AMT_W-1:0];
    end

    // Rotate amount modulo WIDTH, cheap slice when WIDTH is a power of two.
    generate
        if (POW2) begin : g_rot_pow2
            always_comb rot_amt = mag[AMT_W-1:0];
        end else begin : g_rot_mod
            always_comb rot_amt = AMT_W'(mag % MAG_W'(WIDTH));
        end
    endgenerate
endmodule

// File: rtl/sru_shift_core.sv
// Combinational shift/rotate datapath for a direction-resolved operation.
// Assumes: sh_amt is zero when sh_over is set; rot_amt < WIDTH.
module sru_shift_core
    import sru_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]           data_in,
    input  sru_op_e                    op_eff,
    input  logic                       sh_over,
    input  logic [$clog2(WIDTH)-1:0]   sh_amt,
    input  logic [$clog2(WIDTH)-1:0]   rot_amt,
    output logic [WIDTH-1:0]           data_out
);
    localparam logic [WIDTH-1:0] ONES = '1;

    logic [WIDTH-1:0] lo_fill, hi_fill;
    logic [WIDTH-1:0] r_lsl, r_lsr, r_asl, r_asr, r_rol, r_ror;

    // Fill words for the arithmetic forms.
    always_comb begin
        lo_fill = {WIDTH{data_in[0]}};
        hi_fill = {WIDTH{data_in[WIDTH-1]}};
    end

    // Shift variants, saturated when the magnitude reaches WIDTH.
    always_comb begin
        r_lsl = sh_over ? '0 : (data_in << sh_amt);
        r_lsr = sh_over ? '0 : (data_in >> sh_amt);
        r_asl = sh_over ? lo_fill
                        : ((data_in << sh_amt) | (lo_fill & ~(ONES << sh_amt)));
        r_asr = sh_over ? hi_fill
                        : ((data_in >> sh_amt) | (hi_fill & ~(ONES >> sh_amt)));
    end

    // Rotate variants; a zero amount shifts the wrapped part out entirely.
    always_comb begin
        r_rol = (data_in << rot_amt) | (data_in >> (WIDTH - int'(rot_amt)));
        r_ror = (data_in >> rot_amt) | (data_in << (WIDTH - int'(rot_amt)));
    end

    // Result select.
    always_comb begin
        unique case (op_eff)
            OP_LSL:  data_out = r_lsl;
            OP_LSR:  data_out = r_lsr;
            OP_ASL:  data_out = r_asl;
            OP_ASR:  data_out = r_asr;
            OP_ROL:  data_out = r_rol;
            OP_ROR:  data_out = r_ror;
            default: data_out = data_in;
        endcase
    end
endmodule

// File: rtl/sru_out_reg.sv
// Result register and one-cycle valid flag.
// Assumes: synchronous active-low reset that has priority over the strobe.
module sru_out_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] next_data,
    output logic [WIDTH-1:0] q_data,
    output logic             q_valid
);
    // Load on strobe, hold otherwise; valid mirrors the strobe one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load) q_data <= next_data;
        end
    end

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (!q_valid && q_data == '0));
    p_valid_tracks_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q_valid);
    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> !q_valid);
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(q_data));
endmodule

// File: rtl/shift_rotate_unit.sv
// Top of the signed-amount shift and rotate unit.
// Assumes: WIDTH >= 2; count is WIDTH+1-bit two's complement.
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_strobe,
    input  logic [2:0]       op_code,
    input  logic [WIDTH-1:0] op_data,
    input  logic [WIDTH:0]   op_count,
    output logic [WIDTH-1:0] res_data,
    output logic             res_valid
);
    localparam int AMT_W = $clog2(WIDTH);

    sru_op_e          op_eff;
    logic             sh_over;
    logic [AMT_W-1:0] sh_amt;
    logic [AMT_W-1:0] rot_amt;
    logic [WIDTH-1:0] core_out;

    sru_count_decode #(.WIDTH(WIDTH)) u_decode (
        .code_in  (op_code),
        .count_in (op_count),
        .op_eff   (op_eff),
        .sh_over  (sh_over),
        .sh_amt   (sh_amt),
        .rot_amt  (rot_amt)
    );

    sru_shift_core #(.WIDTH(WIDTH)) u_core (
        .data_in  (op_data),
        .op_eff   (op_eff),
        .sh_over  (sh_over),
        .sh_amt   (sh_amt),
        .rot_amt  (rot_amt),
        .data_out (core_out)
    );

    sru_out_reg #(.WIDTH(WIDTH)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (op_strobe),
        .next_data (core_out),
        .q_data    (res_data),
        .q_valid   (res_valid)
    );

    p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && op_count == '0) |=> res_data == $past(op_data));
    p_pass_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && op_code[2:1] == 2'b11) |=> res_data == $past(op_data));
    p_rotate_keeps_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && op_code[2:1] == 2'b10)
            |=> $countones(res_data) == $countones($past(op_data)));
    p_logical_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe && op_code[2:1] == 2'b00 && (op_count[WIDTH] ||
            op_count >= (WIDTH+1)'(WIDTH)) && op_count != '0 &&
            ((~op_count + 1'b1) >= (WIDTH+1)'(WIDTH) || !op_count[WIDTH]))
            |=> res_data == '0);
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
    localparam int W     = 4;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_strobe = 1'b0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] op_data = '0;
    logic [W:0]   op_count = '0;
    logic [W-1:0] res_data;
    logic         res_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    shift_rotate_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .op_code(op_code),
        .op_data(op_data), .op_count(op_count),
        .res_data(res_data), .res_valid(res_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bit-by-bit model from the requirements.
    function automatic logic [W-1:0] model(input int op, input int d, input int c);
        logic [W-1:0] dv = W'(d);
        logic [W-1:0] r = '0;
        int m = (c < 0) ? -c : c;
        int e = op;
        if (c < 0 && op < 6) e = op ^ 1;
        for (int i = 0; i < W; i++) begin
            case (e)
                0: r[i] = (i - m >= 0) ? dv[i-m] : 1'b0;
                1: r[i] = (i + m < W)  ? dv[i+m] : 1'b0;
                2: r[i] = (i - m >= 0) ? dv[i-m] : dv[0];
                3: r[i] = (i + m < W)  ? dv[i+m] : dv[W-1];
                4: r[i] = dv[(((i - m) % W) + W) % W];
                5: r[i] = dv[(i + m) % W];
                default: r[i] = dv[i];
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input int op, input int c);
        int m = (c < 0) ? -c : c;
        if (op >= 6 || c == 0) return "R7";
        if (c == -(1 << W))    return "R8";
        if (m >= W)            return "R6";
        if (c < 0)             return "R5";
        case (op)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int op, input int d, input int c);
        op_strobe = 1'b1;
        op_code   = 3'(op);
        op_data   = W'(d);
        op_count  = (W+1)'(c);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp_r;
        string        exp_t;
        logic         pend;

        // R10: reset wins over a strobe in the same cycle.
        @(negedge clk);
        drive(3, 4'b1011, 1);
        @(negedge clk);
        check("R10", W'(res_valid), W'(0), "valid under reset with strobe");
        check("R10", res_data, '0, "result under reset");
        op_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", W'(res_valid), W'(0), "valid idle after reset");

        // Named corner vectors.
        drive(3, 4'b1100, -1);  @(negedge clk); check("R5", res_data, 4'b1000, "asr -1");
        drive(4, 4'b1100, -1);  @(negedge clk); check("R5", res_data, 4'b0110, "rol -1");
        drive(5, 4'b1100, -1);  @(negedge clk); check("R5", res_data, 4'b1001, "ror -1");
        drive(2, 4'b0111, 1);   @(negedge clk); check("R2", res_data, 4'b1111, "asl fill lsb");
        drive(1, 4'b1101, 3);   @(negedge clk); check("R1", res_data, 4'b0001, "lsr 3");
        drive(3, 4'b1000, -16); @(negedge clk); check("R8", res_data, 4'b0000, "asr most negative");
        drive(4, 4'b1010, -16); @(negedge clk); check("R8", res_data, 4'b1010, "rol most negative");

        // Exhaustive back-to-back sweep: check the previous vector, drive the next.
        pend = 1'b0;
        for (int op = 0; op < 8; op++) begin
            for (int d = 0; d < (1 << W); d++) begin
                for (int c = -(1 << W); c < (1 << W); c++) begin
                    drive(op, d, c);
                    @(negedge clk);
                    if (pend) begin end
                    exp_r = model(op, d, c);
                    exp_t = tag_of(op, c);
                    check(exp_t, res_data, exp_r,
                          $sformatf("op=%0d d=%0d c=%0d", op, d, c));
                    if (!res_valid) check("R9", W'(res_valid), W'(1), "valid after strobe");
                end
            end
        end

        // R9: idle cycle drops valid and holds result.
        exp_r = res_data;
        op_strobe = 1'b0;
        op_data = ~op_data;
        @(negedge clk);
        check("R9", W'(res_valid), W'(0), "valid after idle");
        check("R9", res_data, exp_r, "result held while idle");

        // R10: reset mid-stream with a strobe.
        drive(0, 4'b0001, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", res_data, '0, "result cleared mid-stream");
        check("R10", W'(res_valid), W'(0), "valid cleared mid-stream");
        op_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule